// File: doc/BRIEF.md
# Bus Mastership Handshake Controller

This block is the requester side of a shared system bus. It decides when to ask for the bus, when it may take it, and when it must hand it back. Three active-low lines carry the handshake. The block drives a request line and samples a grant line. It also shares a release line: the system side pulses it to pass mastership over, and the block pulses it to give mastership back. The release line is split into a sampled input, a driven value and an output enable, so the pad sits outside the block.

The core tells the block that it has a transaction pending and which of its resources are ready. It also says when an issue is still in progress near the end of a tenure. The block returns a master flag that enables the bus drivers and a permit strobe that says when the core may start a new issue. Every handshake input first passes through a register stage. All observe-to-act delays, `OBS_LAT` cycles by default, are counted from that registered observation.

Top module: `bus_own_ctrl`

## Requirements
- R1: After reset, req_n_o and rel_n_o are 1, rel_oe_o, master_o and issue_ok_o are 0.
- R2: req_n_o goes low only from the idle slave state, and only when core_pend is 1 and every bit of rsrc_ok is 1 at the same rising edge. It goes low right after that edge. If any of these conditions is missing, req_n_o stays 1.
- R3: Once req_n_o is low, it stays low until grant has been observed, even if core_pend drops to 0.
- R4: If gnt_n_i is first sampled low at rising edge e, req_n_o returns to 1 right after edge e+2.
- R5: If rel_n_i is sampled low at edge e, at or after the edge where grant was first sampled, master_o rises right after edge e+2.
- R6: When grant and release are first sampled low at the same edge e, req_n_o rises and master_o rises together, right after edge e+2.
- R7: master_o stays 1 while gnt_n_i stays low. If gnt_n_i is first sampled high at edge e, issue_ok_o remains 1 up to edge e+2.
- R8: If issue_busy is low at edge e+2, the hand-back pulse starts right after that edge. During the pulse, rel_oe_o is 1 and rel_n_o is 0 for exactly one cycle, and master_o is 0. At all other times rel_oe_o is 0.
- R9: If issue_busy is still high at edge e+2, the pulse is postponed and master_o stays 1. Meanwhile issue_ok_o is 0 and rel_oe_o is 0. The pulse then starts right after the first edge at which issue_busy is sampled low.
- R10: After the pulse the block returns to slave state. A request pending at the edge that ends the pulse does not assert req_n_o. The earliest low on req_n_o follows the next edge.
- R11: A release sampled before any grant has been observed is ignored: master_o stays 0 and req_n_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_pend | input | 1 | Core has a request or coherency response ready |
| rsrc_ok | input | NRES | Per-resource ready bits; all must be 1 |
| issue_busy | input | 1 | Core is still issuing a transaction |
| gnt_n_i | input | 1 | Grant from arbiter, active low |
| rel_n_i | input | 1 | Sampled release line, active low |
| req_n_o | output | 1 | Bus request, active low |
| rel_n_o | output | 1 | Value driven on the release line |
| rel_oe_o | output | 1 | Output enable for the release line |
| master_o | output | 1 | Block owns the bus; enables drivers |
| issue_ok_o | output | 1 | Core may start an issue |

## Verification
The hardest case to reach is the postponed hand-back. It needs grant to drop while a core issue is still busy across the edge that closes the two-cycle window, and then the busy flag must clear some cycles later. The stimulus holds issue_busy high from the cycle grant is withdrawn and releases it three cycles after the window closes. The bench then checks that the pulse follows exactly one edge later and that the permit went low in between. The bench also reaches two other cases: a release that arrives before any grant, and a new request raised on the very edge that ends a pulse.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

   typedef enum logic [2:0] {
      SLAVE_IDLE       = 3'd0,
      REQ_WAIT_GNT     = 3'd1,
      REQ_DROP         = 3'd2,
      WAIT_REL         = 3'd3,
      MASTER           = 3'd4,
      RELINQUISH_DELAY = 3'd5,
      REL_PULSE        = 3'd6
   } own_state_e;

   function automatic logic st_requesting(own_state_e s);
      return (s == REQ_WAIT_GNT) || (s == REQ_DROP);
   endfunction

   function automatic logic st_owning(own_state_e s);
      return (s == MASTER) || (s == RELINQUISH_DELAY);
   endfunction

endpackage

// File: rtl/bus_own_insync.sv
module bus_own_insync #(
   parameter int W     = 2,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("bus_own_insync: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= din;
   end

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= '0;
            else        stage[i] <= stage[i-1];
         end
      end
   endgenerate

   assign dout = stage[DEPTH-1];

endmodule

// File: rtl/bus_own_timer.sv
module bus_own_timer #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);

   localparam int CW = $clog2(LAT + 1);

   generate
      if (LAT < 2) begin : g_bad_lat
         $error("bus_own_timer: LAT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          busy;

   assign fire = busy && (cnt == CW'(LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(1);
      end else if (fire) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
   import bus_own_pkg::*;
#(
   parameter int LAT = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       want,
   input  logic       gnt_seen,
   input  logic       rel_seen,
   input  logic       issue_busy,
   output own_state_e state,
   output logic       req_act,
   output logic       owning,
   output logic       issue_ok,
   output logic       rel_drive
);

   own_state_e nxt;
   logic       rel_seen_d;
   logic       rel_rise;
   logic       win_closed;
   logic       g_start, g_fire;
   logic       r_start, r_fire;
   logic       h_start, h_fire;

   assign rel_rise = rel_seen && !rel_seen_d;

   assign g_start = (state == REQ_WAIT_GNT) && gnt_seen;
   assign r_start = rel_rise &&
                    (((state == REQ_WAIT_GNT) && gnt_seen) ||
                     (state == REQ_DROP) || (state == WAIT_REL));
   assign h_start = (state == MASTER) && !gnt_seen;

   bus_own_timer #(.LAT(LAT)) u_gtmr (
      .clk(clk), .rst_n(rst_n), .start(g_start), .fire(g_fire));
   bus_own_timer #(.LAT(LAT)) u_rtmr (
      .clk(clk), .rst_n(rst_n), .start(r_start), .fire(r_fire));
   bus_own_timer #(.LAT(LAT)) u_htmr (
      .clk(clk), .rst_n(rst_n), .start(h_start), .fire(h_fire));

   always_comb begin
      nxt = state;
      unique case (state)
         SLAVE_IDLE:       if (want) nxt = REQ_WAIT_GNT;
         REQ_WAIT_GNT:     if (gnt_seen) nxt = REQ_DROP;
         REQ_DROP:         if (g_fire) nxt = r_fire ? MASTER : WAIT_REL;
         WAIT_REL:         if (r_fire) nxt = MASTER;
         MASTER:           if (!gnt_seen) nxt = RELINQUISH_DELAY;
         RELINQUISH_DELAY: if ((h_fire || win_closed) && !issue_busy) nxt = REL_PULSE;
         REL_PULSE:        nxt = SLAVE_IDLE;
         default:          nxt = SLAVE_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SLAVE_IDLE;
         rel_seen_d <= 1'b0;
         win_closed <= 1'b0;
      end else begin
         state      <= nxt;
         rel_seen_d <= rel_seen;
         if (state != RELINQUISH_DELAY) win_closed <= 1'b0;
         else if (h_fire)               win_closed <= 1'b1;
      end
   end

   assign req_act   = st_requesting(state);
   assign owning    = st_owning(state);
   assign issue_ok  = (state == MASTER) ||
                      ((state == RELINQUISH_DELAY) && !win_closed);
   assign rel_drive = (state == REL_PULSE);

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
   import bus_own_pkg::*;
#(
   parameter int NRES       = 2,
   parameter int SYNC_DEPTH = 1,
   parameter int OBS_LAT    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            core_pend,
   input  logic [NRES-1:0] rsrc_ok,
   input  logic            issue_busy,
   input  logic            gnt_n_i,
   input  logic            rel_n_i,
   output logic            req_n_o,
   output logic            rel_n_o,
   output logic            rel_oe_o,
   output logic            master_o,
   output logic            issue_ok_o
);

   localparam int HS_W = 2;

   generate
      if (NRES < 1) begin : g_bad_nres
         $error("bus_own_ctrl: NRES must be at least 1");
      end
   endgenerate

   logic [HS_W-1:0] hs_raw, hs_obs;
   logic            want;
   logic            req_act, owning, issue_ok, rel_drive;
   own_state_e      state;

   assign hs_raw = {~gnt_n_i, ~rel_n_i & ~rel_oe_o};

   bus_own_insync #(.W(HS_W), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(hs_raw), .dout(hs_obs));

   assign want = core_pend && (&rsrc_ok);

   bus_own_fsm #(.LAT(OBS_LAT)) u_fsm (
      .clk(clk), .rst_n(rst_n), .want(want),
      .gnt_seen(hs_obs[1]), .rel_seen(hs_obs[0]),
      .issue_busy(issue_busy), .state(state),
      .req_act(req_act), .owning(owning),
      .issue_ok(issue_ok), .rel_drive(rel_drive));

   assign req_n_o    = ~req_act;
   assign master_o   = owning;
   assign issue_ok_o = issue_ok;
   assign rel_oe_o   = rel_drive;
   assign rel_n_o    = ~rel_drive;

endmodule

// File: rtl/bus_own_ctrl_chk.sv
module bus_own_ctrl_chk #(
   parameter int NRES = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            core_pend,
   input logic [NRES-1:0] rsrc_ok,
   input logic            issue_busy,
   input logic            gnt_n_i,
   input logic            rel_n_i,
   input logic            req_n_o,
   input logic            rel_n_o,
   input logic            rel_oe_o,
   input logic            master_o,
   input logic            issue_ok_o
);

   a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rel_oe_o |=> !rel_oe_o);

   a_r8_pulse_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      rel_oe_o |-> !rel_n_o);

   a_r8_pulse_after_tenure: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_oe_o) |-> $past(master_o));

   a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_n_o && gnt_n_i && $past(gnt_n_i)) |=> !req_n_o);

   a_r2_no_req_as_master: assert property (@(posedge clk) disable iff (!rst_n)
      master_o |-> req_n_o);

   a_r7_permit_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ok_o |-> master_o);

endmodule

bind bus_own_ctrl bus_own_ctrl_chk #(.NRES(NRES)) u_chk (.*);

// File: tb/bus_own_ctrl_bench.sv
module bus_own_ctrl_bench;

   localparam int NRES = 2;
   localparam int S_REQ = 0, S_MST = 1, S_OE = 2, S_ISS = 3, S_RELV = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            core_pend = 1'b0;
   logic [NRES-1:0] rsrc_ok = '0;
   logic            issue_busy = 1'b0;
   logic            gnt_n_i = 1'b1;
   logic            rel_n_i = 1'b1;
   logic            req_n_o, rel_n_o, rel_oe_o, master_o, issue_ok_o;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      int    at;
      int    sig;
      logic  val;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;

   bus_own_ctrl #(.NRES(NRES)) u_bus_own_ctrl (
      .clk(clk), .rst_n(rst_n), .core_pend(core_pend), .rsrc_ok(rsrc_ok),
      .issue_busy(issue_busy), .gnt_n_i(gnt_n_i), .rel_n_i(rel_n_i),
      .req_n_o(req_n_o), .rel_n_o(rel_n_o), .rel_oe_o(rel_oe_o),
      .master_o(master_o), .issue_ok_o(issue_ok_o));

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic sig_val(int s);
      case (s)
         S_REQ:   return req_n_o;
         S_MST:   return master_o;
         S_OE:    return rel_oe_o;
         S_ISS:   return issue_ok_o;
         default: return rel_n_o;
      endcase
   endfunction

   function automatic string sig_name(int s);
      case (s)
         S_REQ:   return "req_n_o";
         S_MST:   return "master_o";
         S_OE:    return "rel_oe_o";
         S_ISS:   return "issue_ok_o";
         default: return "rel_n_o";
      endcase
   endfunction

   // driver side: queue an expected value for a future cycle, kept in order
   task automatic expect_at(int at, int s, logic v, string tag);
      exp_t it;
      int   i = 0;
      it.at = at; it.sig = s; it.val = v; it.tag = tag;
      while (i < sb.size() && sb[i].at <= at) i++;
      sb.insert(i, it);
   endtask

   // monitor side: compare due items away from the active edge
   always @(negedge clk) begin
      exp_t e;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         e = sb.pop_front();
         total++;
         if (sig_val(e.sig) !== e.val) begin
            bad++;
            $display("FAIL %s: %s at cycle %0d actual=%b expected=%b",
                     e.tag, sig_name(e.sig), cyc, sig_val(e.sig), e.val);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int n, g, h, r;
      step(3);
      rst_n = 1'b1;
      n = cyc;
      expect_at(n + 1, S_REQ, 1'b1, "R1");
      expect_at(n + 1, S_MST, 1'b0, "R1");
      expect_at(n + 1, S_OE, 1'b0, "R1");
      expect_at(n + 1, S_RELV, 1'b1, "R1");
      expect_at(n + 1, S_ISS, 1'b0, "R1");
      step(2);

      // R2: a missing resource or a missing need keeps the request off
      n = cyc;
      core_pend = 1'b1; rsrc_ok = 2'b01;
      for (int k = 1; k <= 4; k++) expect_at(n + k, S_REQ, 1'b1, "R2");
      step(4);
      n = cyc;
      core_pend = 1'b0; rsrc_ok = 2'b11;
      for (int k = 1; k <= 2; k++) expect_at(n + k, S_REQ, 1'b1, "R2");
      step(2);

      // request, then the need is withdrawn while waiting (R3)
      n = cyc;
      core_pend = 1'b1;
      expect_at(n + 1, S_REQ, 1'b0, "R2");
      step(1);
      core_pend = 1'b0;
      n = cyc;
      for (int k = 1; k <= 4; k++) expect_at(n + k, S_REQ, 1'b0, "R3");
      step(4);

      // grant and release together (R4, R6)
      g = cyc;
      gnt_n_i = 1'b0; rel_n_i = 1'b0;
      expect_at(g + 2, S_REQ, 1'b0, "R4");
      expect_at(g + 2, S_MST, 1'b0, "R6");
      expect_at(g + 3, S_REQ, 1'b1, "R6");
      expect_at(g + 3, S_MST, 1'b1, "R6");
      expect_at(g + 3, S_ISS, 1'b1, "R7");
      step(1);
      rel_n_i = 1'b1;
      step(5);
      expect_at(cyc + 1, S_MST, 1'b1, "R7");
      step(1);

      // hand-back with the issue path idle (R7, R8), then R10
      h = cyc;
      gnt_n_i = 1'b1;
      expect_at(h + 1, S_MST, 1'b1, "R7");
      expect_at(h + 2, S_MST, 1'b1, "R7");
      expect_at(h + 2, S_ISS, 1'b1, "R7");
      expect_at(h + 2, S_OE, 1'b0, "R8");
      expect_at(h + 3, S_OE, 1'b1, "R8");
      expect_at(h + 3, S_RELV, 1'b0, "R8");
      expect_at(h + 3, S_MST, 1'b0, "R8");
      expect_at(h + 3, S_ISS, 1'b0, "R8");
      expect_at(h + 4, S_OE, 1'b0, "R8");
      expect_at(h + 4, S_RELV, 1'b1, "R8");
      step(3);
      core_pend = 1'b1;
      expect_at(h + 4, S_REQ, 1'b1, "R10");
      expect_at(h + 5, S_REQ, 1'b0, "R10");
      step(2);
      core_pend = 1'b0;

      // a release before any grant is ignored (R11)
      n = cyc;
      rel_n_i = 1'b0;
      step(1);
      rel_n_i = 1'b1;
      expect_at(n + 3, S_MST, 1'b0, "R11");
      expect_at(n + 4, S_MST, 1'b0, "R11");
      expect_at(n + 4, S_REQ, 1'b0, "R11");
      step(4);

      // grant now, release arrives later (R4, R5)
      g = cyc;
      gnt_n_i = 1'b0;
      expect_at(g + 3, S_REQ, 1'b1, "R4");
      expect_at(g + 3, S_MST, 1'b0, "R5");
      expect_at(g + 4, S_MST, 1'b0, "R5");
      step(4);
      r = cyc;
      rel_n_i = 1'b0;
      expect_at(r + 2, S_MST, 1'b0, "R5");
      expect_at(r + 3, S_MST, 1'b1, "R5");
      step(1);
      rel_n_i = 1'b1;
      step(4);

      // hand-back postponed by a busy issue (R9)
      h = cyc;
      gnt_n_i = 1'b1; issue_busy = 1'b1;
      expect_at(h + 2, S_ISS, 1'b1, "R7");
      expect_at(h + 3, S_ISS, 1'b0, "R9");
      expect_at(h + 3, S_MST, 1'b1, "R9");
      expect_at(h + 4, S_MST, 1'b1, "R9");
      for (int k = 3; k <= 5; k++) expect_at(h + k, S_OE, 1'b0, "R9");
      step(5);
      issue_busy = 1'b0;
      expect_at(h + 6, S_OE, 1'b1, "R9");
      expect_at(h + 6, S_MST, 1'b0, "R9");
      expect_at(h + 7, S_OE, 1'b0, "R8");
      step(4);

      while (sb.size() > 0) step(1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: run hung at cycle %0d actual=running expected=done", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule